// File: doc/BRIEF.md
# Selectable-Policy Bus Arbiter

This block decides which of several masters owns a single shared bus, for example one processor and three DMA engines. Each master raises its own request line. The arbiter answers with a one-hot grant vector that is held in a register. A bus-busy input lets the master that owns the bus keep it for as many cycles as its transaction needs. While bus-busy is high the grant does not change. On every cycle with the bus free, the arbiter makes a new decision.

A two-bit mode input picks one of three policies:

- **Fixed rank.** The lowest-numbered requester always wins.
- **Rotating priority.** The last winner drops to the lowest priority for the next decision.
- **Weighted slot schedule.** A repeating five-slot rotation gives master 0 (the processor) two slots and each other master one slot. A slot whose owner is not requesting passes to the next requesting owner in the schedule.

Changing the mode restarts the rotation pointers at the next free-bus decision.

Top module: `bus_arbiter`

## Requirements
- R1: When mode is 0 or 3 (fixed rank), the grant issued at a free-bus decision goes to the requesting master with the lowest index.
- R2: When mode is 1 (rotating), the search starts just above the last master granted in this mode and wraps around. After a restart the search starts at master 0.
- R3: When mode is 2 (weighted) and all masters request, successive grants follow the slot owners 0, 1, 0, 2, 3 and then repeat.
- R4: In weighted mode, if the current slot's owner is not requesting, the grant goes to the first requesting owner found by walking forward through the slot order. The slot pointer then advances by exactly one slot from the current slot.
- R5: At most one grant bit is ever high.
- R6: While busBusy is sampled high, the grant register keeps its value, whatever the request and mode inputs are.
- R7: A free-bus decision made with no request pending produces an all-zero grant.
- R8: The grant is registered. A decision made from the inputs sampled at one rising edge appears just after that edge, and it always goes to a master that was requesting at that edge.
- R9: A new mode value takes effect only at a free-bus decision. The first such decision in the new mode starts with both the rotating and the slot pointers at zero.
- R10: While rstN is low, the grant is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy select: 0 fixed, 1 rotating, 2 weighted, 3 fixed |
| req | input | NUM_MASTERS | One request line per master |
| busBusy | input | 1 | High while the current owner holds the bus |
| grant | output | NUM_MASTERS | One-hot registered grant, all zero when idle |

## Verification
The hardest state to reach is a mode change that arrives while the bus is held. The new mode must not act and must not reset the pointers until the first free cycle. To reach it, the stimulus first moves the rotating pointer away from zero. It then switches mode with bus-busy high and releases the bus a cycle later. The weighted skip path needs request patterns that leave slot owners idle at chosen positions of the schedule. A reference model tracks the slot pointer so that each skip lands at a known place.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED    = 2'd0,
    MODE_ROTATE   = 2'd1,
    MODE_WEIGHTED = 2'd2,
    MODE_SPARE    = 2'd3
  } arbMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     arbitrate;  // bus free this cycle: decide
    logic     restart;    // mode differs from last decision: zero pointers
    arbMode_e mode;
  } arbStrobe_t;

  // Owner of a weighted slot: 0,1,0,2,3,...
  function automatic int slotOwner(input int slot);
    if (slot == 0 || slot == 2) return 0;
    if (slot == 1) return 1;
    return slot - 1;
  endfunction

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       busBusy,
  output arbStrobe_t strobe
);

  logic [1:0] lastMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastMode <= 2'd0;
    end else if (!busBusy) begin
      lastMode <= modeIn;
    end
  end

  always_comb begin
    strobe.arbitrate = !busBusy;
    strobe.restart   = !busBusy && (modeIn != lastMode);
    strobe.mode      = arbMode_e'(modeIn);
  end

endmodule

// File: rtl/arb_path.sv
module arb_path
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  arbStrobe_t   strobe,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int SLOT_N = N + 1;
  localparam int SLOT_W = $clog2(SLOT_N);

  logic [IDX_W-1:0]  owner [SLOT_N];
  logic [IDX_W-1:0]  rrPtr, rrBase;
  logic [SLOT_W-1:0] slotPtr, slotBase;

  logic              fixedHit, rrHit, wtHit, winHit;
  logic [IDX_W-1:0]  fixedIdx, rrIdx, wtIdx, winIdx;
  logic [IDX_W-1:0]  rrNext;
  logic [SLOT_W-1:0] slotNext;

  genvar g;
  generate
    for (g = 0; g < SLOT_N; g++) begin : gSlot
      assign owner[g] = IDX_W'(slotOwner(g));
    end
  endgenerate

  always_comb begin
    rrBase   = strobe.restart ? '0 : rrPtr;
    slotBase = strobe.restart ? '0 : slotPtr;

    // Fixed rank: lowest index wins
    fixedHit = 1'b0;
    fixedIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        fixedHit = 1'b1;
        fixedIdx = IDX_W'(i);
      end
    end

    // Rotating: search upward from rrBase
    rrHit = 1'b0;
    rrIdx = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(rrBase) + k;
      if (c >= N) c = c - N;
      if (!rrHit && req[c]) begin
        rrHit = 1'b1;
        rrIdx = IDX_W'(c);
      end
    end

    // Weighted: walk slots from slotBase
    wtHit = 1'b0;
    wtIdx = '0;
    for (int k = 0; k < SLOT_N; k++) begin
      int s;
      s = int'(slotBase) + k;
      if (s >= SLOT_N) s = s - SLOT_N;
      if (!wtHit && req[owner[s]]) begin
        wtHit = 1'b1;
        wtIdx = owner[s];
      end
    end

    case (strobe.mode)
      MODE_ROTATE:   begin winHit = rrHit; winIdx = rrIdx; end
      MODE_WEIGHTED: begin winHit = wtHit; winIdx = wtIdx; end
      default:       begin winHit = fixedHit; winIdx = fixedIdx; end
    endcase

    rrNext   = (int'(winIdx) == N - 1) ? '0 : winIdx + 1'b1;
    slotNext = (int'(slotBase) == SLOT_N - 1) ? '0 : slotBase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant   <= '0;
      rrPtr   <= '0;
      slotPtr <= '0;
    end else if (strobe.arbitrate) begin
      grant   <= winHit ? (N'(1) << winIdx) : '0;
      rrPtr   <= rrBase;
      slotPtr <= slotBase;
      if (winHit && strobe.mode == MODE_ROTATE)   rrPtr   <= rrNext;
      if (winHit && strobe.mode == MODE_WEIGHTED) slotPtr <= slotNext;
    end
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             mode,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   busBusy,
  output logic [NUM_MASTERS-1:0] grant
);

  arbStrobe_t strobe;

  arb_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeIn  (mode),
    .busBusy (busBusy),
    .strobe  (strobe)
  );

  arb_path #(.N(NUM_MASTERS)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .req    (req),
    .grant  (grant)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   mode,
  input logic [N-1:0] req,
  input logic         busBusy,
  input logic [N-1:0] grant
);

  localparam logic [N-1:0] ONE = N'(1);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R5

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |=> $stable(grant)); // R6

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && req == '0) |=> grant == '0); // R7

  AST_GRANT_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && req != '0) |=> (grant & $past(req)) != '0); // R8

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && (mode == 2'd0 || mode == 2'd3) && req != '0)
      |=> grant == ($past(req) & (~$past(req) + ONE))); // R1

endmodule

bind bus_arbiter arb_checker #(.N(NUM_MASTERS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .mode    (mode),
  .req     (req),
  .busBusy (busBusy),
  .grant   (grant)
);

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] req = 4'd0;
  logic       busBusy = 1'b0;
  logic [3:0] grant;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t sb[$];

  // Reference state
  int         mRr = 0, mSlot = 0;
  logic [1:0] mLast = 2'd0;
  logic [3:0] mGrant = 4'd0;
  int         sched [5] = '{0, 1, 0, 2, 3};

  always #4 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(4)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .req(req),
    .busBusy(busBusy), .grant(grant)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [3:0] r, input logic b,
                       input string tag);
    item_t it;
    int win;
    @(negedge clk);
    mode = m; req = r; busBusy = b;
    if (!b) begin
      if (m != mLast) begin mRr = 0; mSlot = 0; mLast = m; end
      win = -1;
      if (m == 2'd1) begin
        for (int k = 0; k < 4; k++)
          if (win < 0 && r[(mRr + k) % 4]) win = (mRr + k) % 4;
        if (win >= 0) mRr = (win + 1) % 4;
      end else if (m == 2'd2) begin
        for (int k = 0; k < 5; k++)
          if (win < 0 && r[sched[(mSlot + k) % 5]]) win = sched[(mSlot + k) % 5];
        if (win >= 0) mSlot = (mSlot + 1) % 5;
      end else begin
        for (int k = 3; k >= 0; k--) if (r[k]) win = k;
      end
      mGrant = (win >= 0) ? (4'd1 << win) : 4'd0;
    end
    it.exp = mGrant;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(grant, it.exp, it.tag);
        checks++;
        if ($countones(grant) > 1) begin
          errors++;
          $display("FAIL R5 actual %b expected at most one bit", grant);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req = 4'b1111;
    repeat (3) @(negedge clk);
    check(grant, 4'b0000, "R10 reset");
    rstN = 1'b1;

    // R1 fixed rank, including spare encoding 3
    drive(2'd0, 4'b1110, 1'b0, "R1");
    drive(2'd0, 4'b1111, 1'b0, "R1");
    drive(2'd0, 4'b1000, 1'b0, "R1");
    drive(2'd3, 4'b1100, 1'b0, "R1 mode3");
    drive(2'd0, 4'b0000, 1'b0, "R7");
    // R8 latency: grant unchanged right after inputs change
    drive(2'd0, 4'b0100, 1'b0, "R8");
    #1 check(grant, 4'b0000, "R8 before edge");
    // R6 hold while busy
    drive(2'd0, 4'b0001, 1'b1, "R6");
    drive(2'd0, 4'b0000, 1'b1, "R6");
    drive(2'd0, 4'b0000, 1'b0, "R7");

    // R2 rotating
    for (int i = 0; i < 5; i++) drive(2'd1, 4'b1111, 1'b0, "R2");
    drive(2'd1, 4'b1010, 1'b0, "R2");
    drive(2'd1, 4'b1010, 1'b0, "R2");
    drive(2'd1, 4'b0101, 1'b0, "R2");

    // R9 mode change under busy, then release
    drive(2'd2, 4'b1111, 1'b1, "R9 busy");
    drive(2'd2, 4'b1111, 1'b0, "R9");
    drive(2'd1, 4'b1111, 1'b0, "R9");
    drive(2'd1, 4'b1111, 1'b0, "R9");
    drive(2'd1, 4'b1111, 1'b1, "R6");

    // R3 weighted schedule, all requesting
    for (int i = 0; i < 10; i++) drive(2'd2, 4'b1111, 1'b0, "R3");
    // R4 skip idle owners
    drive(2'd0, 4'b0000, 1'b0, "R7");
    for (int i = 0; i < 6; i++) drive(2'd2, 4'b1110, 1'b0, "R4");
    drive(2'd2, 4'b0000, 1'b0, "R7");
    for (int i = 0; i < 5; i++) drive(2'd2, 4'b1001, 1'b0, "R4");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule